// File: doc/BRIEF.md
# Rotation-Zoom Coordinate Mapper

The block walks the output raster of a frame that is both rotated and enlarged. For each output pixel it computes the source-image point that pixel samples from. It does this with a single inverse mapping, not with a zoom stage followed by a rotate stage. The raster position is moved to the centre of the output frame, turned by the inverse of the chosen angle, and divided by the zoom factor. The result is then moved back to the centre of the 640 x 512 source frame. Sine and cosine come from a signed Q1.14 table that is filled at elaboration, so no floating-point arithmetic is used.

The result is a source coordinate with 12 integer bits and 8 fractional bits. A downstream stage fetches pixels with the integer part, and an interpolator picks its filter phase from the top fractional bits. A flag marks whether the full 4 x 4 neighbourhood around the point lies inside the source frame. The rotation angle and zoom step are captured on a frame-start strobe and stay fixed for the rest of the frame. The pipeline accepts one pixel per clock and returns each result a fixed 4 cycles later.

Top module: `rotzoom_mapper`

## Requirements
- R1: `map_vld_o` repeats `pix_vld_i` exactly 4 clock cycles later, for any pattern of gaps between pixels, and one result is produced for every accepted pixel.
- R2: `angle_i` and `zoom_i` are captured only in a cycle with `sof_i` high. A later change on either input without `sof_i` has no effect on the coordinates of the pixels that follow.
- R3: When `sof_i` and `pix_vld_i` are high in the same cycle, that pixel already uses the newly presented angle and zoom. Pixels still inside the pipeline keep the settings they entered with.
- R4: With zoom step z, angle index a, s = T(a), c = T(a+64 mod 256), dx = x - (640·2^z)/2 and dy = y - (512·2^z)/2, the source position in 1/256 pixel is U = floor((c·dx + s·dy) / 2^(6+z)) + 320·256 and V = floor((c·dy − s·dx) / 2^(6+z)) + 256·256.
- R5: The table value is T(k) = round(16384·sin(2πk/256)) for k = 0..255. Angle index k stands for k·360/256 degrees, and cosine is read at index k+64.
- R6: `zoom_i` is the base-2 logarithm of the enlargement: 0, 1 and 2 select 1x, 2x and 4x. The value 3 is treated as 2 (4x).
- R7: `src_x_o` and `src_y_o` are bits [19:8] of U and V taken as two's complement, so the integer part is floor(U/256). `frac_x_o` and `frac_y_o` are bits [7:0], and bits [7:4] are the interpolation phase.
- R8: `inb_o` is high exactly when 1 ≤ floor(U/256) ≤ 637 and 1 ≤ floor(V/256) ≤ 509, so that the 4 x 4 neighbourhood from integer−1 to integer+2 lies inside the source frame.
- R9: While `map_vld_o` is low, all coordinate outputs and `inb_o` hold the values of the last result.
- R10: While `rst_ni` is low, and right after reset, `map_vld_o`, `inb_o` and all coordinate outputs are 0. The captured angle and zoom step are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Frame start; captures angle and zoom |
| angle_i | input | 8 | Rotation angle index, 256 steps per turn |
| zoom_i | input | 2 | Base-2 logarithm of the enlargement |
| pix_vld_i | input | 1 | Output pixel strobe |
| out_x_i | input | 12 | Output raster column |
| out_y_i | input | 12 | Output raster row |
| map_vld_o | output | 1 | Result strobe, 4 cycles after the pixel |
| src_x_o | output | 12 | Source column, integer part |
| src_y_o | output | 12 | Source row, integer part |
| frac_x_o | output | 8 | Source column, fraction in 1/256 |
| frac_y_o | output | 8 | Source row, fraction in 1/256 |
| inb_o | output | 1 | 4 x 4 neighbourhood inside the source frame |

## Verification
The settings capture and the pixel mapping can fall in the same cycle. This happens when a frame start arrives together with the first pixel of the new frame while older pixels are still in the pipeline. The bench provokes this in a full sweep of all 256 angles, where every pixel carries its own frame start, and in a random stream where frame starts land at arbitrary points. A behavioural model keeps the captured settings and a 4-deep expectation history, and judges every cycle. The new pixel must use the new angle, and the results already in flight must keep the old one.

// File: rtl/rzm_pkg.sv
package rzm_pkg;

  localparam longint PI_Q30 = 64'sd3373259426;

  // sin over a quarter turn, m steps of (pi/2)/q, Taylor in Q30
  function automatic longint sin_quarter(input longint m, input longint half_n);
    longint x, x2, term, acc;
    x    = (m * PI_Q30) / half_n;
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int n = 1; n <= 9; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // full-turn sine rounded to frac_w fractional bits
  function automatic longint sin_fix(input int k, input int ang_w, input int frac_w);
    longint n_tot, q, idx, seg, m, raw;
    n_tot = longint'(1) << ang_w;
    q     = n_tot / 4;
    idx   = longint'(k) % n_tot;
    seg   = idx / q;
    m     = idx % q;
    case (seg)
      0:       raw =  sin_quarter(m, n_tot / 2);
      1:       raw =  sin_quarter(q - m, n_tot / 2);
      2:       raw = -sin_quarter(m, n_tot / 2);
      default: raw = -sin_quarter(q - m, n_tot / 2);
    endcase
    if (raw >= 0) return (raw + (longint'(1) << (29 - frac_w))) >>> (30 - frac_w);
    return -((-raw + (longint'(1) << (29 - frac_w))) >>> (30 - frac_w));
  endfunction

endpackage

// File: rtl/rzm_trig_rom.sv
module rzm_trig_rom import rzm_pkg::*; #(
  parameter  int ANG_W     = 8,
  parameter  int TRIG_W    = 16,
  parameter  int TRIG_FRAC = 14,
  localparam int N         = 1 << ANG_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ANG_W-1:0]         sin_addr_i,
  input  logic [ANG_W-1:0]         cos_addr_i,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);

  localparam logic signed [TRIG_W-1:0] ONE = TRIG_W'(1 << TRIG_FRAC);
  localparam longint ONE_SQ = longint'(1) << (2 * TRIG_FRAC);
  localparam longint TOL    = longint'(1) << (TRIG_FRAC + 2);

  logic signed [TRIG_W-1:0] lut [N];

  for (genvar g = 0; g < N; g++) begin : g_lut
    assign lut[g] = TRIG_W'(sin_fix(g, ANG_W, TRIG_FRAC));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= ONE;
    end else begin
      sin_o <= lut[sin_addr_i];
      cos_o <= lut[cos_addr_i];
    end
  end

  longint mag;
  always_comb mag = longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o);

  AST_TRIG_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag - ONE_SQ < TOL) && (ONE_SQ - mag < TOL)); // R5

endmodule

// File: rtl/rzm_rotate.sv
module rzm_rotate #(
  parameter  int DW     = 13,
  parameter  int TW     = 16,
  parameter  int ZW     = 2,
  localparam int PROD_W = DW + TW,
  localparam int SUM_W  = PROD_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [DW-1:0]    dx_i,
  input  logic signed [DW-1:0]    dy_i,
  input  logic [ZW-1:0]           zoom_i,
  input  logic signed [TW-1:0]    sin_i,
  input  logic signed [TW-1:0]    cos_i,
  output logic                    vld_o,
  output logic [ZW-1:0]           zoom_o,
  output logic signed [SUM_W-1:0] u_o,
  output logic signed [SUM_W-1:0] v_o
);

  logic                     p_vld;
  logic [ZW-1:0]            p_zoom;
  logic signed [PROD_W-1:0] p_cx, p_sy, p_cy, p_sx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld  <= 1'b0;
      p_zoom <= '0;
      p_cx   <= '0;
      p_sy   <= '0;
      p_cy   <= '0;
      p_sx   <= '0;
    end else begin
      p_vld  <= vld_i;
      p_zoom <= zoom_i;
      p_cx   <= cos_i * dx_i;
      p_sy   <= sin_i * dy_i;
      p_cy   <= cos_i * dy_i;
      p_sx   <= sin_i * dx_i;
    end
  end

  // inverse rotation: source = R(-a) * offset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      zoom_o <= '0;
      u_o    <= '0;
      v_o    <= '0;
    end else begin
      vld_o  <= p_vld;
      zoom_o <= p_zoom;
      u_o    <= SUM_W'(p_cx) + SUM_W'(p_sy);
      v_o    <= SUM_W'(p_cy) - SUM_W'(p_sx);
    end
  end

endmodule

// File: rtl/rzm_axis_finish.sv
module rzm_axis_finish #(
  parameter int SUM_W     = 30,
  parameter int ZW        = 2,
  parameter int DIM       = 640,
  parameter int TRIG_FRAC = 14,
  parameter int FRAC_W    = 8,
  parameter int INT_W     = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic [ZW-1:0]           zoom_i,
  output logic [INT_W-1:0]        int_o,
  output logic [FRAC_W-1:0]       frac_o,
  output logic                    ok_o
);

  localparam int     SH_BASE = TRIG_FRAC - FRAC_W;
  localparam longint OFF     = longint'(DIM / 2) << FRAC_W;

  logic [5:0]              shamt;
  logic signed [SUM_W-1:0] scaled;
  logic signed [SUM_W:0]   pos;
  logic signed [SUM_W:0]   ipart;
  logic                    ok;

  always_comb begin
    shamt  = 6'(SH_BASE) + 6'(zoom_i);
    scaled = sum_i >>> shamt;
    pos    = (SUM_W+1)'(scaled) + (SUM_W+1)'(OFF);
    ipart  = pos >>> FRAC_W;
    ok     = (int'(ipart) >= 1) && (int'(ipart) <= DIM - 3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o  <= '0;
      frac_o <= '0;
      ok_o   <= 1'b0;
    end else if (vld_i) begin
      int_o  <= ipart[INT_W-1:0];
      frac_o <= pos[FRAC_W-1:0];
      ok_o   <= ok;
    end
  end

  AST_OK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (int_o >= INT_W'(1)) && (int'(int_o) <= DIM - 3)); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(int_o) && $stable(frac_o) && $stable(ok_o)); // R9

endmodule

// File: rtl/rotzoom_mapper.sv
module rotzoom_mapper import rzm_pkg::*; #(
  parameter  int SRC_W     = 640,
  parameter  int SRC_H     = 512,
  parameter  int ANG_W     = 8,
  parameter  int ZOOM_MAX  = 2,
  parameter  int TRIG_W    = 16,
  parameter  int TRIG_FRAC = 14,
  parameter  int FRAC_W    = 8,
  parameter  int INT_W     = 12,
  localparam int OUT_MAX   = ((SRC_W > SRC_H) ? SRC_W : SRC_H) << ZOOM_MAX,
  localparam int POS_W     = $clog2(OUT_MAX),
  localparam int ZOOM_W    = (ZOOM_MAX < 1) ? 1 : $clog2(ZOOM_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic [ANG_W-1:0]  angle_i,
  input  logic [ZOOM_W-1:0] zoom_i,
  input  logic              pix_vld_i,
  input  logic [POS_W-1:0]  out_x_i,
  input  logic [POS_W-1:0]  out_y_i,
  output logic              map_vld_o,
  output logic [INT_W-1:0]  src_x_o,
  output logic [INT_W-1:0]  src_y_o,
  output logic [FRAC_W-1:0] frac_x_o,
  output logic [FRAC_W-1:0] frac_y_o,
  output logic              inb_o
);

  localparam int DW    = POS_W + 1;
  localparam int SUM_W = DW + TRIG_W + 1;
  localparam int QTR   = (1 << ANG_W) / 4;

  // frame settings
  logic [ANG_W-1:0]  ang_q, ang_eff;
  logic [ZOOM_W-1:0] zoom_q, zoom_eff, zoom_sat;

  always_comb begin
    zoom_sat = (int'(zoom_i) > ZOOM_MAX) ? ZOOM_W'(ZOOM_MAX) : zoom_i;
    ang_eff  = sof_i ? angle_i  : ang_q;
    zoom_eff = sof_i ? zoom_sat : zoom_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ang_q  <= '0;
      zoom_q <= '0;
    end else if (sof_i) begin
      ang_q  <= angle_i;
      zoom_q <= zoom_sat;
    end
  end

  // stage 1: centre offsets and table read
  logic [POS_W:0]         half_w, half_h;
  logic signed [DW-1:0]   dx_d, dy_d;

  always_comb begin
    half_w = (POS_W+1)'((SRC_W << zoom_eff) >> 1);
    half_h = (POS_W+1)'((SRC_H << zoom_eff) >> 1);
    dx_d   = $signed({1'b0, out_x_i}) - $signed(half_w);
    dy_d   = $signed({1'b0, out_y_i}) - $signed(half_h);
  end

  logic                 s1_vld;
  logic [ZOOM_W-1:0]    s1_zoom;
  logic signed [DW-1:0] s1_dx, s1_dy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_zoom <= '0;
      s1_dx   <= '0;
      s1_dy   <= '0;
    end else begin
      s1_vld  <= pix_vld_i;
      s1_zoom <= zoom_eff;
      s1_dx   <= dx_d;
      s1_dy   <= dy_d;
    end
  end

  logic signed [TRIG_W-1:0] sin_v, cos_v;

  rzm_trig_rom #(
    .ANG_W     (ANG_W),
    .TRIG_W    (TRIG_W),
    .TRIG_FRAC (TRIG_FRAC)
  ) u_rom (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sin_addr_i (ang_eff),
    .cos_addr_i (ang_eff + ANG_W'(QTR)),
    .sin_o      (sin_v),
    .cos_o      (cos_v)
  );

  // stages 2-3: products and sums
  logic                    s3_vld;
  logic [ZOOM_W-1:0]       s3_zoom;
  logic signed [SUM_W-1:0] s3_sum [2];

  rzm_rotate #(
    .DW (DW),
    .TW (TRIG_W),
    .ZW (ZOOM_W)
  ) u_rot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s1_vld),
    .dx_i   (s1_dx),
    .dy_i   (s1_dy),
    .zoom_i (s1_zoom),
    .sin_i  (sin_v),
    .cos_i  (cos_v),
    .vld_o  (s3_vld),
    .zoom_o (s3_zoom),
    .u_o    (s3_sum[0]),
    .v_o    (s3_sum[1])
  );

  // stage 4: scale, re-centre, split, bounds per axis
  logic [INT_W-1:0]  int_q  [2];
  logic [FRAC_W-1:0] frac_q [2];
  logic [1:0]        ok_q;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam int DIM = (a == 0) ? SRC_W : SRC_H;
    rzm_axis_finish #(
      .SUM_W     (SUM_W),
      .ZW        (ZOOM_W),
      .DIM       (DIM),
      .TRIG_FRAC (TRIG_FRAC),
      .FRAC_W    (FRAC_W),
      .INT_W     (INT_W)
    ) u_fin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (s3_vld),
      .sum_i  (s3_sum[a]),
      .zoom_i (s3_zoom),
      .int_o  (int_q[a]),
      .frac_o (frac_q[a]),
      .ok_o   (ok_q[a])
    );
  end

  logic s4_vld;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s4_vld <= 1'b0;
    else         s4_vld <= s3_vld;
  end

  assign map_vld_o = s4_vld;
  assign src_x_o   = int_q[0];
  assign src_y_o   = int_q[1];
  assign frac_x_o  = frac_q[0];
  assign frac_y_o  = frac_q[1];
  assign inb_o     = &ok_q;

  // checks
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4) |-> (map_vld_o == $past(pix_vld_i, 4))); // R1

  AST_SOF_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (ang_q == $past(angle_i))); // R2

  AST_HOLD_SETTINGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(ang_q) && $stable(zoom_q)); // R2

  AST_ZOOM_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(zoom_q) <= ZOOM_MAX); // R6

  AST_INB_AXES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inb_o |-> (src_x_o != '0) && (src_y_o != '0)); // R8

endmodule

// File: tb/rotzoom_mapper_test.sv
module rotzoom_mapper_test;

  localparam int CLK_NS = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof_i = 1'b0;
  logic [7:0]  angle_i = '0;
  logic [1:0]  zoom_i = '0;
  logic        pix_vld_i = 1'b0;
  logic [11:0] out_x_i = '0;
  logic [11:0] out_y_i = '0;
  logic        map_vld_o;
  logic [11:0] src_x_o, src_y_o;
  logic [7:0]  frac_x_o, frac_y_o;
  logic        inb_o;

  always #(CLK_NS / 2) clk_i = ~clk_i;

  rotzoom_mapper uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .angle_i   (angle_i),
    .zoom_i    (zoom_i),
    .pix_vld_i (pix_vld_i),
    .out_x_i   (out_x_i),
    .out_y_i   (out_y_i),
    .map_vld_o (map_vld_o),
    .src_x_o   (src_x_o),
    .src_y_o   (src_y_o),
    .frac_x_o  (frac_x_o),
    .frac_y_o  (frac_y_o),
    .inb_o     (inb_o)
  );

  typedef struct {
    bit     v;
    longint ix, iy, fx, fy;
    bit     inb;
    string  tag;
  } ent_t;

  int     n_chk = 0;
  int     n_fail = 0;
  ent_t   hist [4];
  longint held_ix = 0, held_iy = 0, held_fx = 0, held_fy = 0;
  bit     held_inb = 0;
  int     lat_a = 0, lat_z = 0;
  bit     in_reset = 1;
  int unsigned seed = 32'd12345;

  function automatic longint tbl(int k);
    real r;
    r = 16384.0 * $sin(2.0 * 3.14159265358979323846 * real'(k % 256) / 256.0);
    return (r < 0.0) ? -longint'($rtoi(-r + 0.5)) : longint'($rtoi(r + 0.5));
  endfunction

  function automatic ent_t model(int x, int y, int a, int z, string tag);
    ent_t   e;
    longint dx, dy, s, c, su, sv, pu, pv, iu, iv;
    dx = longint'(x) - longint'((640 << z) / 2);
    dy = longint'(y) - longint'((512 << z) / 2);
    s  = tbl(a);
    c  = tbl(a + 64);
    su = c * dx + s * dy;
    sv = c * dy - s * dx;
    pu = (su >>> (6 + z)) + 320 * 256;
    pv = (sv >>> (6 + z)) + 256 * 256;
    iu = pu >>> 8;
    iv = pv >>> 8;
    e.v   = 1;
    e.ix  = iu & 4095;
    e.iy  = iv & 4095;
    e.fx  = pu & 255;
    e.fy  = pv & 255;
    e.inb = (iu >= 1) && (iu <= 637) && (iv >= 1) && (iv <= 509);
    e.tag = tag;
    return e;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: compare outputs, then drive this cycle's inputs
  task automatic tick(bit sof, int a, int z, bit vld, int x, int y, string tag);
    ent_t  e, old;
    string ft;
    @(negedge clk_i);
    old = hist[3];
    if (old.v) begin
      held_ix = old.ix; held_iy = old.iy; held_fx = old.fx; held_fy = old.fy;
      held_inb = old.inb;
      ft = old.tag;
    end else begin
      ft = in_reset ? "R10" : "R9";
    end
    chk("R1", "valid", longint'(map_vld_o), longint'(old.v));
    chk(ft, "src_x", longint'(src_x_o), held_ix);
    chk(ft, "src_y", longint'(src_y_o), held_iy);
    chk(ft, "frac_x", longint'(frac_x_o), held_fx);
    chk(ft, "frac_y", longint'(frac_y_o), held_fy);
    chk(old.v ? "R8" : ft, "inb", longint'(inb_o), longint'(held_inb));
    sof_i     = sof;
    angle_i   = 8'(a);
    zoom_i    = 2'(z);
    pix_vld_i = vld;
    out_x_i   = 12'(x);
    out_y_i   = 12'(y);
    if (sof) begin
      lat_a = a % 256;
      lat_z = (z > 2) ? 2 : z;
    end
    e.v = 0; e.ix = 0; e.iy = 0; e.fx = 0; e.fy = 0; e.inb = 0; e.tag = tag;
    if (vld && !in_reset) e = model(x, y, lat_a, lat_z, tag);
    hist[3] = hist[2];
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = e;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      hist[i].v = 0; hist[i].tag = "R10";
    end
    // R10: reset state
    idle(5, "R10");
    @(negedge clk_i);
    rst_ni = 1'b1;
    in_reset = 0;
    idle(3, "R10");
    in_reset = 1;
    idle(2, "R10");
    in_reset = 0;

    // R4: centre and axis points, 4x, angles 0 and 90 degrees
    tick(1, 0, 2, 1, 1280, 1024, "R4");
    tick(0, 0, 2, 1, 1300, 1000, "R4");
    tick(0, 0, 2, 1, 100, 2000, "R4");
    tick(1, 64, 2, 1, 1400, 900, "R4");
    tick(0, 64, 2, 1, 2000, 1500, "R4");
    tick(1, 32, 2, 1, 1700, 1300, "R4");

    // R7: fractional splits, including negative offsets
    tick(1, 0, 2, 1, 1281, 1024, "R7");
    tick(0, 0, 2, 1, 1282, 1025, "R7");
    tick(0, 0, 2, 1, 1283, 1026, "R7");
    tick(0, 0, 2, 1, 1279, 1023, "R7");
    tick(1, 200, 2, 1, 1277, 1021, "R7");

    // R5: every angle, R3 since each carries its own frame start
    for (int k = 0; k < 256; k++)
      tick(1, k, 2, 1, (k * 37) % 2560, (k * 53) % 2048, "R5");
    idle(4, "R5");

    // R6: other zoom steps; 3 saturates
    tick(1, 20, 0, 1, 10, 500, "R6");
    tick(0, 20, 0, 1, 639, 0, "R6");
    tick(1, 90, 1, 1, 1279, 1023, "R6");
    tick(0, 90, 1, 1, 5, 700, "R6");
    tick(1, 150, 3, 1, 2559, 2047, "R6");
    tick(0, 150, 3, 1, 1000, 333, "R6");

    // R2: input changes without frame start are ignored
    tick(1, 40, 1, 0, 0, 0, "R2");
    tick(0, 99, 0, 1, 600, 400, "R2");
    tick(0, 7, 2, 1, 900, 800, "R2");
    tick(0, 180, 3, 1, 1200, 1000, "R2");

    // R3: frame start with pixel, older pixels in flight
    tick(0, 0, 0, 1, 640, 512, "R3");
    tick(1, 128, 2, 1, 640, 512, "R3");
    tick(0, 0, 0, 1, 1500, 1100, "R3");

    // R8: bounds edges at 1x, no rotation
    tick(1, 0, 0, 1, 0, 256, "R8");
    tick(0, 0, 0, 1, 1, 256, "R8");
    tick(0, 0, 0, 1, 637, 256, "R8");
    tick(0, 0, 0, 1, 638, 256, "R8");
    tick(0, 0, 0, 1, 320, 0, "R8");
    tick(0, 0, 0, 1, 320, 1, "R8");
    tick(0, 0, 0, 1, 320, 509, "R8");
    tick(0, 0, 0, 1, 320, 510, "R8");

    // R9: gaps hold the last result
    idle(6, "R9");
    tick(1, 77, 2, 1, 333, 1999, "R9");
    idle(7, "R9");

    // R1: random stream, random gaps and frame starts
    for (int i = 0; i < 1500; i++) begin
      int z;
      seed = seed * 32'd1103515245 + 32'd12345;
      z = int'(seed[25:24]);
      tick(seed[17:13] == 5'd0, int'(seed[31:24]), z, seed[5] | seed[9], int'(seed[23:12]) % 2560,
           int'(seed[11:0]) % 2048, "R1");
    end
    idle(8, "R1");

    summary();
    $finish;
  end

endmodule